// File: doc/BRIEF.md
# Three-Tier Memory Access Arbiter

This block decides which of up to eleven memory agents owns the memory port next. One decision is made each time the port is free and at least one agent requests. The chosen agent sees its bit of a one-hot grant vector. It keeps that grant until it signals end-of-transfer. The agent may then release the port, or a waiting request may take the port on the same clock edge.

Right after reset the arbiter is in a boot mode, where it rotates fairly over all requesters. Once software raises `run_cfg`, three programmed tiers are consulted in strict order:

- A 128-slot time-division wheel. It bounds the worst-case wait of the agents that own slots on it.
- A 16-entry priority list. It reserves bandwidth for the agents named on it.
- A two-level round-robin. It shares the remaining decisions among best-effort agents.

Software fills two complete parameter banks through a one-cycle write port and picks the live bank with `bank_sel`. There is no data path through the block. A grant is the "valid" side of a transfer, and `eot` is the only back-pressure: the port stays owned for as long as `eot` is withheld.

Top module: `hybrid_mem_arb`

## Requirements
- R1: After reset `grant` is all zero. While `run_cfg` is 0, decisions rotate over the requesting agents: the search starts at agent 0 and, after each grant, restarts just above the agent last granted.
- R2: `grant` is one-hot or zero. A new grant goes only to an agent that requested in the decision cycle. A grant stays unchanged until `eot` is high for the granted agent; `eot` of any other agent has no effect.
- R3: A decision is taken on a clock edge where no grant is held, or where the owner's `eot` is high, and `req` is non-zero. The new grant is visible after that edge, so back-to-back grants need no idle cycle. When the owner's `eot` is high and `req` is zero, `grant` returns to zero after that edge.
- R4: When `run_cfg` is 1, every grant advances a wheel pointer by one slot, modulo 128; the pointer starts at 0. Wheel slot codes are the agent number XOR 8: agents 0–7 are written as 0x8–0xF and agents 8–10 as 0x0–0x2. Codes 0x3–0x7 name no agent and are skipped. If the agent named by the current slot requests, it wins over every other tier.
- R5: If the wheel does not pick, the priority list is scanned from entry 0 (highest) to entry 15. The first entry whose agent requests wins. List codes are plain agent numbers, and any code of 11 or above (0xF is the unused value) is skipped.
- R6: If neither the wheel nor the priority list picks, the first-level round-robin scans its 16 slots cyclically from its pointer. The first eligible slot wins, and the pointer moves to the slot after the winner. The pointer starts at 0 and moves only on a round-robin grant.
- R7: First-level slot 15 stands for the whole second level. That slot is eligible when any of the 8 second-level entries names a requesting agent. The second level then picks cyclically from its own pointer, and that pointer moves past the granted entry only.
- R8: Two banks each hold a wheel, a priority list and both round-robin lists. The bank named by `bank_sel` in the decision cycle is used. Changing `bank_sel` while a grant is held does not alter that grant.
- R9: A write on `cfg_we` stores `cfg_data` into bank `cfg_bank` of the table chosen by `cfg_tbl`. The encoding is 0 for the wheel, 1 for the priority list, 2 for the first round-robin level and 3 for the second. Each write goes to entry `cfg_addr`; an address at or beyond the table's length is ignored. After reset every wheel slot holds 0x7 and every list entry holds 0xF.
- R10: With `run_cfg` 1, an agent that owns a wheel slot in the live bank and requests continuously is granted within 128 consecutive decisions, even if higher-listed priority agents request every time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_cfg | input | 1 | 0 = boot rotation, 1 = programmed tiers |
| bank_sel | input | 1 | Live parameter bank |
| req | input | 11 | Per-agent request |
| eot | input | 11 | Per-agent end-of-transfer |
| grant | output | 11 | One-hot grant, held until the owner's eot |
| cfg_we | input | 1 | Table write strobe |
| cfg_bank | input | 1 | Bank targeted by the write |
| cfg_tbl | input | 2 | Table select (0 wheel, 1 priority, 2 rr level 1, 3 rr level 2) |
| cfg_addr | input | 7 | Entry index |
| cfg_data | input | 4 | Agent code to store |

## Verification
Boot mode is driven first with every agent requesting, which shows the plain rotation order. It is then driven with random sparse request sets, which show that idle agents are skipped without losing the rotation position. In programmed mode, directed request sets are chosen to reach exactly one tier each: a wheel owner against a priority agent, two priority agents, first-level-only agents and second-level-only agents. A wrong tier order or a wrong pointer step then yields a different grant sequence. Random request sets with random hold lengths, stray `eot` pulses on other agents and bank flips during grants test isolation. A final run lets two always-requesting priority agents compete with two wheel owners, which separates a correct latency bound from a priority tier that starves the wheel.

// File: rtl/hybrid_mem_arb_pkg.sv
package hybrid_mem_arb_pkg;
  typedef enum logic [1:0] {
    TBL_WHEEL = 2'd0,
    TBL_PRIO  = 2'd1,
    TBL_RR1   = 2'd2,
    TBL_RR2   = 2'd3
  } tbl_e;

  typedef enum logic [2:0] {
    TIER_NONE,
    TIER_BOOT,
    TIER_WHEEL,
    TIER_PRIO,
    TIER_RR
  } tier_e;
endpackage

// File: rtl/arb_rot_pick.sv
// Cyclic search: first set bit of elig at or after ptr, wrapping.
module arb_rot_pick #(
  parameter int W  = 16,
  parameter int PW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  elig,
  input  logic [PW-1:0] ptr,
  output logic          found,
  output logic [PW-1:0] idx
);
  always_comb begin
    int j;
    found = 1'b0;
    idx   = '0;
    for (int k = W - 1; k >= 0; k--) begin
      j = int'(ptr) + k;
      if (j >= W) j = j - W;
      if (elig[j]) begin
        found = 1'b1;
        idx   = PW'(j);
      end
    end
  end
endmodule

// File: rtl/arb_prio_pick.sv
// Fixed-order scan of the priority list: lowest entry naming a requester wins.
module arb_prio_pick #(
  parameter int NA    = 11,
  parameter int IDW   = 4,
  parameter int SLOTS = 16
) (
  input  logic [SLOTS*IDW-1:0] list,
  input  logic [NA-1:0]        req,
  output logic                 found,
  output logic [IDW-1:0]       id
);
  logic [SLOTS-1:0] elig;

  for (genvar s = 0; s < SLOTS; s++) begin : g_elig
    logic [IDW-1:0] code;
    assign code = list[s*IDW +: IDW];
    always_comb begin
      elig[s] = 1'b0;
      if (int'(code) < NA) elig[s] = req[code];
    end
  end

  always_comb begin
    found = 1'b0;
    id    = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (elig[s]) begin
        found = 1'b1;
        id    = list[s*IDW +: IDW];
      end
    end
  end
endmodule

// File: rtl/arb_cfg_tables.sv
// Two banks of wheel, priority and round-robin tables with one write port.
module arb_cfg_tables
  import hybrid_mem_arb_pkg::*;
#(
  parameter int IDW    = 4,
  parameter int WSLOTS = 128,
  parameter int PSLOTS = 16,
  parameter int R1SLOTS = 16,
  parameter int R2SLOTS = 8,
  parameter int WAW    = $clog2(WSLOTS),
  parameter logic [IDW-1:0] WHEEL_NONE = 4'h7,
  parameter logic [IDW-1:0] LIST_NONE  = 4'hF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     wr_bank,
  input  logic [1:0]               wr_tbl,
  input  logic [WAW-1:0]           wr_addr,
  input  logic [IDW-1:0]           wr_data,
  input  logic                     rd_bank,
  input  logic [WAW-1:0]           wheel_idx,
  output logic [IDW-1:0]           wheel_code,
  output logic [PSLOTS*IDW-1:0]    prio_list,
  output logic [R1SLOTS*IDW-1:0]   rr1_list,
  output logic [R2SLOTS*IDW-1:0]   rr2_list
);
  logic [IDW-1:0] wheel_m [2][WSLOTS];
  logic [IDW-1:0] prio_m  [2][PSLOTS];
  logic [IDW-1:0] rr1_m   [2][R1SLOTS];
  logic [IDW-1:0] rr2_m   [2][R2SLOTS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++) begin
        for (int i = 0; i < WSLOTS; i++)  wheel_m[b][i] <= WHEEL_NONE;
        for (int i = 0; i < PSLOTS; i++)  prio_m[b][i]  <= LIST_NONE;
        for (int i = 0; i < R1SLOTS; i++) rr1_m[b][i]   <= LIST_NONE;
        for (int i = 0; i < R2SLOTS; i++) rr2_m[b][i]   <= LIST_NONE;
      end
    end else if (wr_en) begin
      case (tbl_e'(wr_tbl))
        TBL_WHEEL: if (int'(wr_addr) < WSLOTS)  wheel_m[wr_bank][int'(wr_addr)] <= wr_data;
        TBL_PRIO:  if (int'(wr_addr) < PSLOTS)  prio_m[wr_bank][int'(wr_addr)]  <= wr_data;
        TBL_RR1:   if (int'(wr_addr) < R1SLOTS) rr1_m[wr_bank][int'(wr_addr)]   <= wr_data;
        default:   if (int'(wr_addr) < R2SLOTS) rr2_m[wr_bank][int'(wr_addr)]   <= wr_data;
      endcase
    end
  end

  assign wheel_code = wheel_m[rd_bank][int'(wheel_idx)];

  for (genvar s = 0; s < PSLOTS; s++) begin : g_prio
    assign prio_list[s*IDW +: IDW] = prio_m[rd_bank][s];
  end
  for (genvar s = 0; s < R1SLOTS; s++) begin : g_rr1
    assign rr1_list[s*IDW +: IDW] = rr1_m[rd_bank][s];
  end
  for (genvar s = 0; s < R2SLOTS; s++) begin : g_rr2
    assign rr2_list[s*IDW +: IDW] = rr2_m[rd_bank][s];
  end
endmodule

// File: rtl/hybrid_mem_arb.sv
// Wheel over priority list over two-level round-robin, with a boot rotation.
module hybrid_mem_arb
  import hybrid_mem_arb_pkg::*;
#(
  parameter int NA      = 11,
  parameter int IDW     = 4,
  parameter int WSLOTS  = 128,
  parameter int PSLOTS  = 16,
  parameter int R1SLOTS = 16,
  parameter int R2SLOTS = 8,
  parameter int WMAP    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       run_cfg,
  input  logic                       bank_sel,
  input  logic [NA-1:0]              req,
  input  logic [NA-1:0]              eot,
  output logic [NA-1:0]              grant,
  input  logic                       cfg_we,
  input  logic                       cfg_bank,
  input  logic [1:0]                 cfg_tbl,
  input  logic [$clog2(WSLOTS)-1:0]  cfg_addr,
  input  logic [IDW-1:0]             cfg_data
);
  localparam int WAW = $clog2(WSLOTS);
  localparam int BPW = $clog2(NA);
  localparam int P1W = $clog2(R1SLOTS);
  localparam int P2W = $clog2(R2SLOTS);
  localparam int R1_LAST = R1SLOTS - 1;

  function automatic logic code_hit(input logic [IDW-1:0] code, input logic [NA-1:0] r);
    code_hit = 1'b0;
    if (int'(code) < NA) code_hit = r[code];
  endfunction

  logic [NA-1:0]  grant_q;
  logic [BPW-1:0] boot_ptr;
  logic [WAW-1:0] wheel_ptr;
  logic [P1W-1:0] rr1_ptr;
  logic [P2W-1:0] rr2_ptr;

  logic [IDW-1:0]           wheel_code;
  logic [PSLOTS*IDW-1:0]    prio_list;
  logic [R1SLOTS*IDW-1:0]   rr1_list;
  logic [R2SLOTS*IDW-1:0]   rr2_list;

  arb_cfg_tables #(
    .IDW(IDW), .WSLOTS(WSLOTS), .PSLOTS(PSLOTS),
    .R1SLOTS(R1SLOTS), .R2SLOTS(R2SLOTS), .WAW(WAW)
  ) u_tables (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_bank(cfg_bank), .wr_tbl(cfg_tbl),
    .wr_addr(cfg_addr), .wr_data(cfg_data),
    .rd_bank(bank_sel), .wheel_idx(wheel_ptr),
    .wheel_code(wheel_code), .prio_list(prio_list),
    .rr1_list(rr1_list), .rr2_list(rr2_list)
  );

  // boot rotation over raw requests
  logic           boot_found;
  logic [BPW-1:0] boot_idx;
  arb_rot_pick #(.W(NA), .PW(BPW)) u_boot (
    .elig(req), .ptr(boot_ptr), .found(boot_found), .idx(boot_idx)
  );

  // wheel tier
  logic [IDW-1:0] wheel_agent;
  logic           wheel_hit;
  assign wheel_agent = wheel_code ^ IDW'(WMAP);
  assign wheel_hit   = code_hit(wheel_agent, req);

  // priority tier
  logic           prio_found;
  logic [IDW-1:0] prio_id;
  arb_prio_pick #(.NA(NA), .IDW(IDW), .SLOTS(PSLOTS)) u_prio (
    .list(prio_list), .req(req), .found(prio_found), .id(prio_id)
  );

  // round-robin tier, second level feeds the last first-level slot
  logic [R2SLOTS-1:0] rr2_elig;
  logic               rr2_found;
  logic [P2W-1:0]     rr2_idx;
  for (genvar s = 0; s < R2SLOTS; s++) begin : g_rr2_elig
    assign rr2_elig[s] = code_hit(rr2_list[s*IDW +: IDW], req);
  end
  arb_rot_pick #(.W(R2SLOTS), .PW(P2W)) u_rr2 (
    .elig(rr2_elig), .ptr(rr2_ptr), .found(rr2_found), .idx(rr2_idx)
  );

  logic [R1SLOTS-1:0] rr1_elig;
  logic               rr1_found;
  logic [P1W-1:0]     rr1_idx;
  for (genvar s = 0; s < R1_LAST; s++) begin : g_rr1_elig
    assign rr1_elig[s] = code_hit(rr1_list[s*IDW +: IDW], req);
  end
  assign rr1_elig[R1_LAST] = rr2_found;
  arb_rot_pick #(.W(R1SLOTS), .PW(P1W)) u_rr1 (
    .elig(rr1_elig), .ptr(rr1_ptr), .found(rr1_found), .idx(rr1_idx)
  );

  logic rr_to_l2;
  assign rr_to_l2 = (rr1_idx == P1W'(R1_LAST));

  // tier selection
  tier_e          tier;
  logic [IDW-1:0] win_id;
  always_comb begin
    tier   = TIER_NONE;
    win_id = '0;
    if (!run_cfg) begin
      if (boot_found) begin
        tier   = TIER_BOOT;
        win_id = IDW'(boot_idx);
      end
    end else if (wheel_hit) begin
      tier   = TIER_WHEEL;
      win_id = wheel_agent;
    end else if (prio_found) begin
      tier   = TIER_PRIO;
      win_id = prio_id;
    end else if (rr1_found) begin
      tier   = TIER_RR;
      win_id = rr_to_l2 ? rr2_list[int'(rr2_idx)*IDW +: IDW]
                        : rr1_list[int'(rr1_idx)*IDW +: IDW];
    end
  end

  logic [NA-1:0] win_oh;
  for (genvar a = 0; a < NA; a++) begin : g_win_oh
    assign win_oh[a] = (tier != TIER_NONE) && (win_id == IDW'(a));
  end

  logic release_now, port_open, decide;
  assign release_now = |(eot & grant_q);
  assign port_open   = (grant_q == '0) || release_now;
  assign decide      = port_open && (req != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_q <= '0;
    end else if (decide) begin
      grant_q <= win_oh;
    end else if (release_now) begin
      grant_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_ptr  <= '0;
      wheel_ptr <= '0;
      rr1_ptr   <= '0;
      rr2_ptr   <= '0;
    end else if (decide && tier != TIER_NONE) begin
      if (tier == TIER_BOOT) begin
        boot_ptr <= (boot_idx == BPW'(NA - 1)) ? '0 : boot_idx + 1'b1;
      end else begin
        wheel_ptr <= (wheel_ptr == WAW'(WSLOTS - 1)) ? '0 : wheel_ptr + 1'b1;
        if (tier == TIER_RR) begin
          rr1_ptr <= rr_to_l2 ? '0 : rr1_idx + 1'b1;
          if (rr_to_l2)
            rr2_ptr <= (rr2_idx == P2W'(R2SLOTS - 1)) ? '0 : rr2_idx + 1'b1;
        end
      end
    end
  end

  assign grant = grant_q;
endmodule

// File: rtl/hybrid_mem_arb_chk.sv
module hybrid_mem_arb_chk #(
  parameter int NA = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_cfg,
  input logic [NA-1:0] req,
  input logic [NA-1:0] eot,
  input logic [NA-1:0] grant
);
  // R2: at most one owner
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R2: a fresh grant belongs to an agent that was requesting
  p_fresh_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && grant != $past(grant)) |-> (($past(req) & grant) != '0));

  // R2: no owner eot, grant holds
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && (eot & grant) == '0) |=> $stable(grant));

  // R3: owner eot with no requests frees the port
  p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && (eot & grant) != '0 && req == '0) |=> grant == '0);

  // R1 / R3: in boot mode an idle port with requests is granted next cycle
  p_boot_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_cfg && grant == '0 && req != '0) |=> grant != '0);
endmodule

bind hybrid_mem_arb hybrid_mem_arb_chk #(.NA(NA)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_cfg(run_cfg),
  .req(req), .eot(eot), .grant(grant)
);

// File: tb/hybrid_mem_arb_tb.sv
module hybrid_mem_arb_tb;
  localparam int NA = 11;
  localparam int WS = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run_cfg = 1'b0;
  logic          bank_sel = 1'b0;
  logic [NA-1:0] req = '0;
  logic [NA-1:0] eot = '0;
  logic [NA-1:0] grant;
  logic          cfg_we = 1'b0;
  logic          cfg_bank = 1'b0;
  logic [1:0]    cfg_tbl = 2'd0;
  logic [6:0]    cfg_addr = '0;
  logic [3:0]    cfg_data = '0;

  always #10 clk = ~clk;

  hybrid_mem_arb u_dut (
    .clk(clk), .rst_n(rst_n), .run_cfg(run_cfg), .bank_sel(bank_sel),
    .req(req), .eot(eot), .grant(grant),
    .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_tbl(cfg_tbl),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data)
  );

  int n_vec = 0;
  int n_err = 0;
  bit finished = 1'b0;

  // bench copy of the tables and pointers
  logic [3:0] tw [2][WS];
  logic [3:0] tp [2][16];
  logic [3:0] t1 [2][16];
  logic [3:0] t2 [2][8];
  int m_bptr = 0, m_wp = 0, m_p1 = 0, m_p2 = 0;

  function automatic logic [NA-1:0] oh(input int a);
    logic [NA-1:0] v = '0;
    v[a] = 1'b1;
    return v;
  endfunction

  function automatic bit ok_code(input logic [3:0] c, input logic [NA-1:0] r);
    if (int'(c) >= NA) return 1'b0;
    return r[c];
  endfunction

  function automatic logic [NA-1:0] model_pick(input logic [NA-1:0] r);
    int b, a, s, t;
    logic [3:0] c;
    if (r == '0) return '0;
    if (!run_cfg) begin
      for (int k = 0; k < NA; k++) begin
        a = (m_bptr + k) % NA;
        if (r[a]) begin m_bptr = (a + 1) % NA; return oh(a); end
      end
      return '0;
    end
    b = int'(bank_sel);
    c = tw[b][m_wp] ^ 4'h8;
    if (ok_code(c, r)) begin m_wp = (m_wp + 1) % WS; return oh(int'(c)); end
    for (int k = 0; k < 16; k++) begin
      c = tp[b][k];
      if (ok_code(c, r)) begin m_wp = (m_wp + 1) % WS; return oh(int'(c)); end
    end
    for (int k = 0; k < 16; k++) begin
      s = (m_p1 + k) % 16;
      if (s == 15) begin
        for (int j = 0; j < 8; j++) begin
          t = (m_p2 + j) % 8;
          c = t2[b][t];
          if (ok_code(c, r)) begin
            m_p2 = (t + 1) % 8; m_p1 = 0; m_wp = (m_wp + 1) % WS;
            return oh(int'(c));
          end
        end
      end else begin
        c = t1[b][s];
        if (ok_code(c, r)) begin
          m_p1 = (s + 1) % 16; m_wp = (m_wp + 1) % WS;
          return oh(int'(c));
        end
      end
    end
    return '0;
  endfunction

  task automatic check(input bit good, input string tag,
                       input logic [NA-1:0] act, input logic [NA-1:0] exp);
    n_vec++;
    if (!good) begin
      n_err++;
      $display("FAIL %s: grant=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input bit b, input int tbl, input int addr, input logic [3:0] d);
    cfg_we = 1'b1; cfg_bank = b; cfg_tbl = 2'(tbl); cfg_addr = 7'(addr); cfg_data = d;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
    case (tbl)
      0: if (addr < WS) tw[b][addr] = d;
      1: if (addr < 16) tp[b][addr] = d;
      2: if (addr < 16) t1[b][addr] = d;
      default: if (addr < 8) t2[b][addr] = d;
    endcase
  endtask

  // one arbitration: request, hold with stray eot, release
  task automatic xact(input logic [NA-1:0] r, input int hold, input bit flip,
                      input string tag, output logic [NA-1:0] got);
    logic [NA-1:0] e;
    req = r; eot = '0;
    e = model_pick(r);
    @(posedge clk); @(negedge clk);
    check(grant == e, tag, grant, e);
    got = grant;
    for (int h = 0; h < hold; h++) begin
      req = '0;
      eot = NA'($urandom) & ~e;
      if (flip) bank_sel = ~bank_sel;
      @(posedge clk); @(negedge clk);
      check(grant == e, flip ? "R8 hold across bank flip" : "R2 hold", grant, e);
    end
    req = '0; eot = e;
    @(posedge clk); @(negedge clk);
    check(grant == '0, "R3 release", grant, '0);
    eot = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: grant=%h expected=%h", grant, '0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    logic [NA-1:0] g, e1, e2;
    int cnt4, cnt8;
    void'($urandom(32'd1234));
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < WS; i++) tw[b][i] = 4'h7;
      for (int i = 0; i < 16; i++) begin tp[b][i] = 4'hF; t1[b][i] = 4'hF; end
      for (int i = 0; i < 8; i++) t2[b][i] = 4'hF;
    end
    repeat (3) @(negedge clk);
    check(grant == '0, "R1 reset", grant, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(grant == '0, "R1 idle after reset", grant, '0);

    // R1: boot rotation, all requesting then sparse
    for (int i = 0; i < NA; i++) xact('1, 0, 1'b0, "R1 boot full", g);
    for (int i = 0; i < 20; i++) xact(NA'($urandom), $urandom_range(0, 2), 1'b0, "R1 boot sparse", g);

    // R3: back-to-back grant on the owner's eot edge
    req = oh(4); e1 = model_pick(req);
    @(posedge clk); @(negedge clk);
    check(grant == e1, "R3 first", grant, e1);
    eot = grant; req = oh(7); e2 = model_pick(req);
    @(posedge clk); @(negedge clk);
    check(grant == e2, "R3 back-to-back", grant, e2);
    req = '0; eot = e2;
    @(posedge clk); @(negedge clk);
    check(grant == '0, "R3 release", grant, '0);
    eot = '0;

    // R9: program bank 0 (wheel codes are agent XOR 8)
    for (int i = 0; i < WS; i++) begin
      if (i % 8 == 0)      cfg_write(1'b0, 0, i, 4'hB); // agent 3
      else if (i % 8 == 4) cfg_write(1'b0, 0, i, 4'h1); // agent 9
      else if (i % 8 == 2) cfg_write(1'b0, 0, i, 4'h5); // no agent
    end
    cfg_write(1'b0, 1, 0, 4'd5);
    cfg_write(1'b0, 1, 2, 4'd1);
    cfg_write(1'b0, 1, 3, 4'd12);
    begin
      int rr1v [15] = '{0, 1, 2, 15, 4, 15, 6, 0, 1, 2, 15, 15, 4, 6, 15};
      int rr2v [8]  = '{7, 10, 15, 8, 7, 15, 10, 8};
      for (int i = 0; i < 15; i++) cfg_write(1'b0, 2, i, 4'(rr1v[i]));
      for (int i = 0; i < 8; i++)  cfg_write(1'b0, 3, i, 4'(rr2v[i]));
    end
    cfg_write(1'b0, 1, 16, 4'd2); // beyond priority list length: ignored
    // bank 1: a sparse wheel and two greedy priority agents
    cfg_write(1'b1, 0, 40, 4'hC);  // agent 4
    cfg_write(1'b1, 0, 100, 4'h0); // agent 8
    cfg_write(1'b1, 1, 0, 4'd0);
    cfg_write(1'b1, 1, 1, 4'd1);

    run_cfg = 1'b1; bank_sel = 1'b0;
    xact(oh(2) | oh(5), 0, 1'b0, "R9 out-of-range write ignored", g);
    for (int i = 0; i < 16; i++) xact(oh(3) | oh(5), 0, 1'b0, "R4 wheel over priority", g);
    for (int i = 0; i < 8; i++)  xact(oh(1) | oh(5), 0, 1'b0, "R5 list order", g);
    for (int i = 0; i < 14; i++) xact(oh(0) | oh(2) | oh(4) | oh(6), 0, 1'b0, "R6 level-1 rotation", g);
    for (int i = 0; i < 12; i++) xact(oh(7) | oh(8) | oh(10), 0, 1'b0, "R7 level-2 rotation", g);
    for (int i = 0; i < 10; i++) xact(oh(0) | oh(7), 0, 1'b0, "R7 level-2 slot in level-1 ring", g);
    for (int i = 0; i < 120; i++)
      xact(NA'($urandom), $urandom_range(0, 2), 1'($urandom_range(0, 1)), "R4/R5/R6/R7/R8 random", g);

    // R10: bank 1, every agent requests every time
    bank_sel = 1'b1; cnt4 = 0; cnt8 = 0;
    for (int i = 0; i < WS; i++) begin
      xact('1, 0, 1'b0, "R10 decision", g);
      if (g[4]) cnt4++;
      if (g[8]) cnt8++;
    end
    check(cnt4 == 1, "R10 agent 4 served in one revolution", NA'(cnt4), NA'(1));
    check(cnt8 == 1, "R10 agent 8 served in one revolution", NA'(cnt8), NA'(1));

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule